// File: doc/BRIEF.md
# Rename Undo Log

This block keeps an ordered log of register renames for a single-threaded out-of-order core. For every rename, the rename stage pushes a record holding the instruction sequence number, the architectural destination, the freshly allocated physical register and the physical register that was mapped before it. The log is a circular buffer with a parameterised depth. When the buffer is full, a rename must wait.

When the pipeline is flushed, a squash request carries the sequence number of the youngest surviving instruction. The block then walks back from the youngest record, undoing one record per cycle. For each record it undoes, it writes the prior mapping back into the external map table and returns the new physical register to the external free list. If that new register lies at or above a configured threshold, it also marks the register ready in the external scoreboard. While the walk runs, `busy` stays high and every other request is ignored.

Commit retires records from the oldest end, one per cycle. Each retired record's prior physical register goes back to the free list.

Top module: `rename_undo_log`

## Requirements
- R1: After a synchronous active-high reset, `empty`=1, `full`=0, `count`=0, `busy`=0, `push_ready`=1, and `map_we`, `free_we` and `sb_we` are all 0.
- R2: A push stores one record and raises `count` by one at the next edge when `push_valid`=1, `push_ready`=1 and `squash_valid`=0. `push_ready` equals `!full && !busy`.
- R3: `full` is 1 exactly when `count` equals DEPTH. A push while full is ignored and changes no stored record.
- R4: An accepted squash with a non-empty log sets `busy` at the next edge. On each later edge, if the youngest record's sequence number is greater than the squash sequence number (unsigned compare), that record is removed. One cycle after that edge, `map_we`=1 with `map_areg` set to the record's architectural register and `map_preg` set to its prior physical register.
- R5: The same undo step drives `free_we`=1 with `free_preg` equal to the record's new physical register.
- R6: The same undo step drives `sb_we`=1 with `sb_preg` equal to the new physical register exactly when that register is at least PREG_LIMIT (default 96).
- R7: The walk ends at the first edge where the log is empty or the youngest sequence number is not greater than the squash sequence number. `busy` falls after that edge, and the records that were not undone stay in place.
- R8: A squash that arrives while the log is empty leaves `busy` low and produces no strobes.
- R9: `commit_valid` with a non-empty log removes the oldest record. One cycle later it drives `free_we`=1 with `free_preg` set to that record's prior physical register and `map_we`=0. On an empty log the commit is ignored.
- R10: While `busy` is 1, push, commit and squash requests are ignored. When not busy, a squash takes priority: a push or commit presented in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Request to log a rename |
| push_seq | input | SEQ_W | Sequence number of the renamed instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly allocated physical register |
| push_old_preg | input | PREG_W | Previously mapped physical register |
| push_ready | output | 1 | A push is accepted this cycle |
| commit_valid | input | 1 | Retire the oldest record |
| squash_valid | input | 1 | Start a rollback |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| busy | output | 1 | Rollback walk in progress |
| full | output | 1 | Log holds DEPTH records |
| empty | output | 1 | Log holds no records |
| count | output | $clog2(DEPTH+1) | Number of stored records |
| map_we | output | 1 | Map table restore strobe |
| map_areg | output | AREG_W | Architectural register to restore |
| map_preg | output | PREG_W | Physical register to map back |
| free_we | output | 1 | Free list return strobe |
| free_preg | output | PREG_W | Physical register returned |
| sb_we | output | 1 | Scoreboard set-ready strobe |
| sb_preg | output | PREG_W | Physical register marked ready |

## Verification
The assertions assume that the rename stage pushes sequence numbers in increasing order and never lets a sequence number wrap within the window the log holds. Under that assumption, an undo always removes younger work before older work. The stimulus keeps a running sequence counter that only grows, by 1 to 3 per push, and picks squash points among values near the youngest logged number. This exercises walks that undo none, some or all of the records. Physical register numbers are drawn over their full range, so records on both sides of the scoreboard threshold occur often.

// File: rtl/rul_pkg.sv
package rul_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_UNDO   = 2'd1,
    OP_RETIRE = 2'd2
  } rul_op_e;
endpackage

// File: rtl/rul_store.sv
module rul_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rul_ctrl.sv
module rul_ctrl
  import rul_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic             commit_valid,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [SEQ_W-1:0] newest_seq,
  output rul_op_e          op,
  output logic             wr_en,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    newest_ptr,
  output logic [AW-1:0]    oldest_ptr,
  output logic             busy,
  output logic             full,
  output logic             empty,
  output logic             push_ready,
  output logic [CW-1:0]    count
);
  logic [SEQ_W-1:0] sq_r;
  logic             start_walk, end_walk;

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign push_ready = !full && !busy;
  assign newest_ptr = wr_ptr - AW'(1);

  always_comb begin
    op         = OP_IDLE;
    wr_en      = 1'b0;
    start_walk = 1'b0;
    end_walk   = 1'b0;
    if (busy) begin
      if (!empty && (newest_seq > sq_r)) op = OP_UNDO;
      else                               end_walk = 1'b1;
    end else if (squash_valid) begin
      start_walk = 1'b1;
    end else begin
      if (commit_valid && !empty) op = OP_RETIRE;
      wr_en = push_valid && !full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      oldest_ptr <= '0;
      count      <= '0;
      busy       <= 1'b0;
      sq_r       <= '0;
    end else begin
      if (start_walk) begin
        sq_r <= squash_seq;
        busy <= !empty;
      end
      if (end_walk) busy <= 1'b0;
      if (op == OP_UNDO)   wr_ptr     <= newest_ptr;
      if (op == OP_RETIRE) oldest_ptr <= oldest_ptr + AW'(1);
      if (wr_en)           wr_ptr     <= wr_ptr + AW'(1);
      case ({wr_en, op != OP_IDLE})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rename_undo_log.sv
module rename_undo_log
  import rul_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int SEQ_W      = 16,
  parameter int AREG_W     = 5,
  parameter int PREG_W     = 7,
  parameter int PREG_LIMIT = 96,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new_preg,
  input  logic [PREG_W-1:0] push_old_preg,
  output logic              push_ready,
  input  logic              commit_valid,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              busy,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count,
  output logic              map_we,
  output logic [AREG_W-1:0] map_areg,
  output logic [PREG_W-1:0] map_preg,
  output logic              free_we,
  output logic [PREG_W-1:0] free_preg,
  output logic              sb_we,
  output logic [PREG_W-1:0] sb_preg
);
  localparam int AW = $clog2(DEPTH);
  localparam int W  = SEQ_W + AREG_W + 2 * PREG_W;
  localparam logic [PREG_W-1:0] SB_LIM = PREG_W'(PREG_LIMIT);

  rul_op_e       op;
  logic          wr_en;
  logic [AW-1:0] wr_ptr, newest_ptr, oldest_ptr;
  logic [W-1:0]  newest, oldest;

  logic [SEQ_W-1:0]  n_seq;
  logic [AREG_W-1:0] n_areg;
  logic [PREG_W-1:0] n_new, n_old, o_old;
  logic              unused_oldest;

  assign {n_seq, n_areg, n_new, n_old} = newest;
  assign o_old         = oldest[PREG_W-1:0];
  assign unused_oldest = ^oldest[W-1:PREG_W];

  rul_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .push_valid   (push_valid),
    .commit_valid (commit_valid),
    .squash_valid (squash_valid),
    .squash_seq   (squash_seq),
    .newest_seq   (n_seq),
    .op           (op),
    .wr_en        (wr_en),
    .wr_ptr       (wr_ptr),
    .newest_ptr   (newest_ptr),
    .oldest_ptr   (oldest_ptr),
    .busy         (busy),
    .full         (full),
    .empty        (empty),
    .push_ready   (push_ready),
    .count        (count)
  );

  rul_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_ptr),
    .wdata   ({push_seq, push_areg, push_new_preg, push_old_preg}),
    .raddr_a (newest_ptr),
    .rdata_a (newest),
    .raddr_b (oldest_ptr),
    .rdata_b (oldest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      map_we    <= 1'b0;
      map_areg  <= '0;
      map_preg  <= '0;
      free_we   <= 1'b0;
      free_preg <= '0;
      sb_we     <= 1'b0;
      sb_preg   <= '0;
    end else begin
      map_we    <= (op == OP_UNDO);
      map_areg  <= n_areg;
      map_preg  <= n_old;
      free_we   <= (op != OP_IDLE);
      free_preg <= (op == OP_UNDO) ? n_new : o_old;
      sb_we     <= (op == OP_UNDO) && (n_new >= SB_LIM);
      sb_preg   <= n_new;
    end
  end
endmodule

// File: rtl/rul_checks.sv
module rul_checks #(
  parameter int DEPTH      = 16,
  parameter int PREG_W     = 7,
  parameter int PREG_LIMIT = 96,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_ready,
  input logic              squash_valid,
  input logic              busy,
  input logic              full,
  input logic              empty,
  input logic [CW-1:0]     count,
  input logic              map_we,
  input logic              free_we,
  input logic [PREG_W-1:0] free_preg,
  input logic              sb_we,
  input logic [PREG_W-1:0] sb_preg
);
  localparam logic [PREG_W-1:0] LIM = PREG_W'(PREG_LIMIT);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> !push_ready);
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !push_ready);
  p_undo_in_walk_r4: assert property (@(posedge clk) disable iff (rst)
    map_we |-> $past(busy));
  p_undo_frees_r5: assert property (@(posedge clk) disable iff (rst)
    map_we |-> free_we);
  p_sb_range_r6: assert property (@(posedge clk) disable iff (rst)
    sb_we |-> (map_we && sb_preg == free_preg && sb_preg >= LIM));
  p_retire_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (free_we && !map_we) |-> !$past(busy));
  p_empty_squash_r8: assert property (@(posedge clk) disable iff (rst)
    (squash_valid && !busy && empty) |=> (!busy && !map_we));
endmodule

bind rename_undo_log rul_checks #(
  .DEPTH(DEPTH), .PREG_W(PREG_W), .PREG_LIMIT(PREG_LIMIT)
) u_checks (.*);

// File: tb/sim_rename_undo_log.sv
`timescale 1ns/1ps
module sim_rename_undo_log;
  localparam int DEPTH = 16;
  localparam int LIM   = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 0, commit_valid = 0, squash_valid = 0;
  logic [15:0] push_seq = 0, squash_seq = 0;
  logic [4:0]  push_areg = 0;
  logic [6:0]  push_new_preg = 0, push_old_preg = 0;
  logic        push_ready, busy, full, empty, map_we, free_we, sb_we;
  logic [4:0]  count, map_areg;
  logic [6:0]  map_preg, free_preg, sb_preg;

  always #2.5 clk = ~clk;

  rename_undo_log u0 (.*);

  typedef struct { logic [15:0] s; logic [4:0] a; logic [6:0] n, o; } ent_t;
  ent_t q[$];
  bit          m_busy;
  logic [15:0] m_sq;
  bit          e_map, e_free, e_sb;
  logic [4:0]  e_mareg;
  logic [6:0]  e_mpreg, e_fpreg, e_sbpreg;
  int          tests = 0, fails = 0;
  bit          done = 0;
  logic [15:0] nseq = 16'd1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void model(bit pv, ent_t pe, bit cv, bit sv, logic [15:0] ss);
    bit was_full;
    e_map = 0; e_free = 0; e_sb = 0;
    if (m_busy) begin
      if (q.size() > 0 && q[$].s > m_sq) begin
        ent_t x = q.pop_back();
        e_map = 1; e_mareg = x.a; e_mpreg = x.o;
        e_free = 1; e_fpreg = x.n;
        e_sb = (x.n >= LIM); e_sbpreg = x.n;
      end else m_busy = 0;
    end else if (sv) begin
      m_sq = ss; m_busy = (q.size() > 0);
    end else begin
      was_full = (q.size() == DEPTH);
      if (cv && q.size() > 0) begin
        ent_t x = q.pop_front();
        e_free = 1; e_fpreg = x.o;
      end
      if (pv && !was_full) q.push_back(pe);
    end
  endfunction

  task automatic step(bit pv, logic [15:0] ps, bit cv, bit sv, logic [15:0] ss);
    ent_t pe;
    @(negedge clk);
    pe.s = ps; pe.a = 5'($urandom); pe.n = 7'($urandom); pe.o = 7'($urandom);
    push_valid = pv; push_seq = ps; push_areg = pe.a;
    push_new_preg = pe.n; push_old_preg = pe.o;
    commit_valid = cv; squash_valid = sv; squash_seq = ss;
    model(pv, pe, cv, sv, ss);
    @(posedge clk); #1;
    chk(busy == m_busy, "R7", "busy", busy, m_busy);
    chk(count == q.size(), "R2", "count", count, q.size());
    chk(full == (q.size() == DEPTH), "R3", "full", full, q.size() == DEPTH);
    chk(push_ready == (!m_busy && q.size() != DEPTH), "R10", "push_ready", push_ready, !m_busy && q.size() != DEPTH);
    chk(map_we == e_map, "R4", "map_we", map_we, e_map);
    if (e_map) begin
      chk(map_areg == e_mareg, "R4", "map_areg", map_areg, e_mareg);
      chk(map_preg == e_mpreg, "R4", "map_preg", map_preg, e_mpreg);
    end
    chk(free_we == e_free, e_map ? "R5" : "R9", "free_we", free_we, e_free);
    if (e_free) chk(free_preg == e_fpreg, e_map ? "R5" : "R9", "free_preg", free_preg, e_fpreg);
    chk(sb_we == e_sb, "R6", "sb_we", sb_we, e_sb);
    if (e_sb) chk(sb_preg == e_sbpreg, "R6", "sb_preg", sb_preg, e_sbpreg);
  endtask

  task automatic push1();
    step(1, nseq, 0, 0, 0);
    nseq += 16'(1 + $urandom % 3);
  endtask

  task automatic drain();
    while (m_busy) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(empty && !full && count == 0 && !busy && push_ready, "R1", "reset flags", {empty, full, busy, push_ready}, 4'b1001);
    chk(!map_we && !free_we && !sb_we, "R1", "reset strobes", {map_we, free_we, sb_we}, 0);
    // R8: squash on empty log
    step(0, 0, 0, 1, 16'd3);
    chk(!busy, "R8", "busy after empty squash", busy, 0);
    step(0, 0, 0, 0, 0);
    chk(!map_we && !free_we, "R8", "no strobes", {map_we, free_we}, 0);
    // R3: fill and overfill
    for (int i = 0; i < DEPTH + 2; i++) push1();
    chk(full && count == DEPTH, "R3", "full after overfill", count, DEPTH);
    // R10: push and commit during busy, squash that undoes three
    step(0, 0, 0, 1, q[DEPTH-4].s);
    step(1, nseq, 1, 1, 0);
    drain();
    chk(count == DEPTH - 3, "R7", "count after partial walk", count, DEPTH - 3);
    // R7: squash that undoes nothing
    step(0, 0, 0, 1, 16'hFFFF);
    drain();
    chk(count == DEPTH - 3, "R7", "count after empty walk", count, DEPTH - 3);
    // R10: squash with simultaneous push and commit
    step(1, nseq, 1, 1, 16'hFFFF);
    drain();
    chk(count == DEPTH - 3, "R10", "count after priority", count, DEPTH - 3);
    // R9: retire a few, then undo all
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 16'd0);
    drain();
    chk(empty, "R4", "empty after full walk", empty, 1);
    step(0, 0, 1, 0, 0);
    chk(!free_we, "R9", "commit on empty", free_we, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      if (r < 6 && q.size() > 0) begin
        logic [15:0] top = q[$].s;
        logic [15:0] ss = (top > 8) ? top - 16'($urandom % 9) : 16'($urandom % 4);
        step($urandom % 2, nseq, $urandom % 2, 1, ss);
      end else begin
        bit pv = ($urandom % 100) < 55;
        step(pv, nseq, ($urandom % 100) < 40, 0, 0);
        if (pv) nseq += 16'(1 + $urandom % 3);
      end
    end
    drain();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule